// File: doc/BRIEF.md
# Sampled Glitch-Rejection Input Filter

This block cleans up slow digital inputs (encoder phases, index marks, general-purpose inputs) before any counting logic uses them. Each raw input is first brought into the clock domain by a short flop chain. It is then sampled only on a periodic sample strobe. The filtered output moves to a new level only after the last three samples all show that level. Noise pulses that span too few sample points therefore never reach the output.

The system clock is treated as a 16 MHz reference. A shared strobe generator divides it by 2, 4 or 8, which gives sample rates of 8, 4 or 2 MHz. A 2-bit select input picks the rate. A slower rate rejects wider noise pulses:
- Any pulse shorter than two sample periods is always dropped.
- A pulse shorter than three sample periods may be dropped, depending on its phase. That is up to 375 ns at 8 MHz, 750 ns at 4 MHz and 1.5 us at 2 MHz.

All channels share one strobe, so a rate change applies to every input at once.

Top module: `gf_input_filter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, every filtered output is 0.
- R2: The sample strobe is high for exactly one clock cycle per sample period. The period is 2 cycles for select 2'b00 (8 MHz), 4 cycles for 2'b01 (4 MHz) and 8 cycles for 2'b10 (2 MHz).
- R3: Select value 2'b11 behaves exactly as 2'b10: 8-cycle strobe period and the same filtering.
- R4: A raw input passes through two synchronizer flops before sampling. A level driven between clock edges is first seen by a strobe edge at least two edges later.
- R5: An output takes a new level at the strobe edge that collects the third consecutive sample of that level. If the input changes just before a strobe edge E0 and holds, the output changes at edge E0 + 3·P, where P is the period in cycles.
- R6: An input pulse that covers fewer than three strobe edges never changes the output. A pulse of one or two full sample periods counts as such a pulse.
- R7: An output changes only in the cycle that follows a strobe cycle.
- R8: A new select value takes effect only at a strobe boundary. The period in progress finishes at its old length, and the next period uses the new length.
- R9: Changing the select while the inputs are steady produces no output edge.
- R10: Channels filter independently on the shared strobe. Activity on one input never moves another channel's output.
- R11: Falling transitions are filtered in the same way as rising ones. After a held-high pulse of W periods, the output returns to 0 at edge E0 + (W + 3)·P.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (16 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 2 | Sample-rate select: 00 = /2, 01 = /4, 10 and 11 = /8 |
| din | input | NUM_CH | Raw asynchronous inputs, one bit per channel |
| dout | output | NUM_CH | Filtered outputs |
| sample_stb | output | 1 | One-cycle sample strobe shared by all channels |

## Verification
Two events can fall on the same edge: a select change reaching a strobe boundary, and the third agreeing sample that makes an output change. The bench provokes this by holding a new input level at the 4-cycle rate. It then switches the select to the 2-cycle rate in the cycle just before the strobe edge where the output is due to rise. It judges the result by two things: the output must still rise on that exact edge, and the very next strobe must arrive two cycles later. A separate run changes the select in mid-period with all inputs steady. That run confirms the old period completes and no output edge appears.

// File: rtl/gf_pkg.sv
package gf_pkg;

   // Encoded sample-rate select; the reserved code falls back to the slowest rate.
   typedef enum logic [1:0] {
      RATE_FAST = 2'b00,
      RATE_MID  = 2'b01,
      RATE_SLOW = 2'b10,
      RATE_RSVD = 2'b11
   } rate_sel_e;

   // Number of doublings of the fastest divider selected by a rate code.
   function automatic int unsigned rate_shift(input logic [1:0] sel);
      case (sel)
         RATE_FAST: return 0;
         RATE_MID:  return 1;
         default:   return 2;
      endcase
   endfunction

endpackage

// File: rtl/gf_strobe_gen.sv
module gf_strobe_gen
   import gf_pkg::*;
#(
   parameter int unsigned FAST_DIV_LOG2 = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] rate_sel,
   output logic       stb
);

   localparam int unsigned CNT_W = FAST_DIV_LOG2 + 2;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last_q;

   function automatic logic [CNT_W-1:0] last_count(input logic [1:0] sel);
      return CNT_W'((1 << (FAST_DIV_LOG2 + rate_shift(sel))) - 1);
   endfunction

   // The terminal count is reloaded only at a period boundary, so a select
   // change never shortens or stretches the period in progress.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         last_q <= last_count(RATE_FAST);
      end else if (cnt_q == last_q) begin
         cnt_q  <= '0;
         last_q <= last_count(rate_sel);
      end else begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   assign stb = (cnt_q == last_q);

endmodule

// File: rtl/gf_sync.sv
module gf_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/gf_vote_filter.sv
module gf_vote_filter #(
   parameter int unsigned AGREE_N = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stb,
   input  logic d,
   output logic q
);

   logic [AGREE_N-2:0] hist_q;
   logic [AGREE_N-1:0] window;
   logic               q_r;

   // Window = the samples already held plus the one taken at this strobe.
   assign window = {hist_q, d};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '0;
         q_r    <= 1'b0;
      end else if (stb) begin
         hist_q <= window[AGREE_N-2:0];
         if (&window)       q_r <= 1'b1;
         else if (~|window) q_r <= 1'b0;
      end
   end

   assign q = q_r;

endmodule

// File: rtl/gf_input_filter.sv
module gf_input_filter #(
   parameter int unsigned NUM_CH        = 3,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter int unsigned AGREE_N       = 3,
   parameter int unsigned FAST_DIV_LOG2 = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        rate_sel,
   input  logic [NUM_CH-1:0] din,
   output logic [NUM_CH-1:0] dout,
   output logic              sample_stb
);

   if (NUM_CH < 1) begin : g_bad_ch
      $error("gf_input_filter: NUM_CH must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gf_input_filter: SYNC_STAGES must be at least 2");
   end
   if (AGREE_N < 2) begin : g_bad_agree
      $error("gf_input_filter: AGREE_N must be at least 2");
   end
   if (FAST_DIV_LOG2 < 1) begin : g_bad_div
      $error("gf_input_filter: FAST_DIV_LOG2 must be at least 1");
   end

   logic              stb;
   logic [NUM_CH-1:0] synced;

   gf_strobe_gen #(
      .FAST_DIV_LOG2(FAST_DIV_LOG2)
   ) u_stb (
      .clk      (clk),
      .rst_n    (rst_n),
      .rate_sel (rate_sel),
      .stb      (stb)
   );

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      gf_sync #(
         .STAGES(SYNC_STAGES)
      ) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (din[ch]),
         .q     (synced[ch])
      );

      gf_vote_filter #(
         .AGREE_N(AGREE_N)
      ) u_filt (
         .clk   (clk),
         .rst_n (rst_n),
         .stb   (stb),
         .d     (synced[ch]),
         .q     (dout[ch])
      );
   end

   assign sample_stb = stb;

endmodule

// File: rtl/gf_input_filter_chk.sv
module gf_input_filter_chk #(
   parameter int unsigned NUM_CH        = 3,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter int unsigned AGREE_N       = 3,
   parameter int unsigned FAST_DIV_LOG2 = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        rate_sel,
   input logic [NUM_CH-1:0] din,
   input logic [NUM_CH-1:0] dout,
   input logic              sample_stb
);

   localparam int unsigned GAP_W  = FAST_DIV_LOG2 + 3;
   localparam int unsigned GAP_P0 = 1 << FAST_DIV_LOG2;
   localparam int unsigned GAP_P1 = 2 << FAST_DIV_LOG2;
   localparam int unsigned GAP_P2 = 4 << FAST_DIV_LOG2;

   logic [2:0]       up_cnt;
   logic [GAP_W-1:0] gap;
   logic             seen_stb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         up_cnt   <= '0;
         gap      <= '0;
         seen_stb <= 1'b0;
      end else begin
         if (up_cnt != 3'd7) up_cnt <= up_cnt + 1'b1;
         if (sample_stb) begin
            gap      <= GAP_W'(1);
            seen_stb <= 1'b1;
         end else if (gap != '1) begin
            gap <= gap + 1'b1;
         end
      end
   end

   p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (dout == '0));

   p_stb_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |=> !sample_stb);

   p_stb_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_stb && seen_stb) |->
         (gap == GAP_W'(GAP_P0) || gap == GAP_W'(GAP_P1) || gap == GAP_W'(GAP_P2)));

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch_chk
      p_edge_after_stb_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (up_cnt >= 3'd1 && dout[i] != $past(dout[i])) |-> $past(sample_stb));

      if (SYNC_STAGES == 2) begin : g_lat
         p_follows_input_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (up_cnt >= 3'd3 && dout[i] != $past(dout[i])) |-> (dout[i] == $past(din[i], 3)));
      end
   end

endmodule

bind gf_input_filter gf_input_filter_chk #(
   .NUM_CH        (NUM_CH),
   .SYNC_STAGES   (SYNC_STAGES),
   .AGREE_N       (AGREE_N),
   .FAST_DIV_LOG2 (FAST_DIV_LOG2)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rate_sel   (rate_sel),
   .din        (din),
   .dout       (dout),
   .sample_stb (sample_stb)
);

// File: tb/gf_input_filter_test.sv
`timescale 1ns/1ps
module gf_input_filter_test;

   localparam int NUM_CH = 3;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [1:0]        rate_sel;
   logic [NUM_CH-1:0] din;
   logic [NUM_CH-1:0] dout;
   logic              sample_stb;

   int checks   = 0;
   int failures = 0;
   bit done     = 0;

   gf_input_filter uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .rate_sel   (rate_sel),
      .din        (din),
      .dout       (dout),
      .sample_stb (sample_stb)
   );

   always #2.5 clk = ~clk;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int period_of(input logic [1:0] s);
      return (s == 2'b00) ? 2 : (s == 2'b01) ? 4 : 8;
   endfunction

   task automatic wait_stb();
      do @(negedge clk); while (!sample_stb);
   endtask

   task automatic measure_gap(input logic [1:0] s, input string req);
      int n;
      rate_sel = s;
      repeat (20) @(negedge clk);
      wait_stb();
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!sample_stb);
      check(n == period_of(s), req, n, period_of(s));
   endtask

   // Pulse of w sample periods on channel 0, launched just before a strobe edge.
   task automatic run_pulse(input logic [1:0] s, input int w, input string tag);
      int p, rise, fall;
      bit side;
      p = period_of(s);
      rate_sel = s;
      din = '0;
      repeat (40) @(negedge clk);
      wait_stb();
      din[0] = 1'b1;
      rise = -1;
      fall = -1;
      side = 0;
      for (int k = 1; k <= (w + 6) * p + 2; k++) begin
         @(negedge clk);
         if (rise < 0 && dout[0]) rise = k;
         if (rise >= 0 && fall < 0 && !dout[0]) fall = k;
         if (dout[NUM_CH-1:1] != '0) side = 1;
         if (k == w * p) din[0] = 1'b0;
      end
      if (w >= 3) begin
         check(rise == 3 * p + 1, {"R5 R4 R7 rise latency ", tag}, rise, 3 * p + 1);
         check(fall == (w + 3) * p + 1, {"R11 fall latency ", tag}, fall, (w + 3) * p + 1);
      end else begin
         check(rise == -1, {"R6 short pulse rejected ", tag}, rise, -1);
      end
      check(side == 0, {"R10 other channels still ", tag}, side, 0);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int s1, s2, base_k;
      bit moved, stb12;
      logic [NUM_CH-1:0] held;

      rst_n    = 1'b0;
      rate_sel = 2'b00;
      din      = '0;
      repeat (3) @(negedge clk);
      check(dout == '0, "R1 outputs low in reset", dout, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(dout == '0, "R1 outputs low after release", dout, 0);

      measure_gap(2'b00, "R2 period sel00");
      measure_gap(2'b01, "R2 period sel01");
      measure_gap(2'b10, "R2 period sel10");
      measure_gap(2'b11, "R3 period sel11");

      for (int s = 0; s < 4; s++) begin
         for (int w = 1; w <= 4; w++) begin
            run_pulse(2'(s), w, $sformatf("sel=%0d w=%0d%s", s, w, (s == 3) ? " R3" : ""));
         end
      end

      // R8 / R9: select change mid-period with steady inputs (all high).
      rate_sel = 2'b10;
      din = '1;
      repeat (60) @(negedge clk);
      held = dout;
      check(held == '1, "R9 outputs settled high", held, 7);
      wait_stb();
      s1 = -1;
      s2 = -1;
      moved = 0;
      for (int k = 1; k <= 14; k++) begin
         @(negedge clk);
         if (sample_stb) begin
            if (s1 < 0) s1 = k;
            else if (s2 < 0) s2 = k;
         end
         if (dout != held) moved = 1;
         if (k == 1) rate_sel = 2'b00;
      end
      check(s1 == 8, "R8 old period completes", s1, 8);
      check(s2 == 10, "R8 new period applies", s2, 10);
      check(moved == 0, "R9 no output edge on select change", moved, 0);

      // Coincidence: select change lands on the strobe edge that raises the output.
      din = '0;
      rate_sel = 2'b01;
      repeat (60) @(negedge clk);
      wait_stb();
      din[0] = 1'b1;
      base_k = 3 * 4;
      stb12 = 0;
      for (int k = 1; k <= base_k + 2; k++) begin
         @(negedge clk);
         if (k == base_k) begin
            check(dout[0] == 1'b0, "R5 output still low before third sample", dout[0], 0);
            rate_sel = 2'b00;
         end
         if (k == base_k + 1) begin
            check(dout[0] == 1'b1, "R5 rise on switching edge", dout[0], 1);
            stb12 = sample_stb;
         end
         if (k == base_k + 2)
            check(sample_stb == 1'b1 && stb12 == 0, "R8 next strobe two cycles later",
                  sample_stb, 1);
      end
      din = '0;
      repeat (20) @(negedge clk);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule